// File: doc/BRIEF.md
# Fixed-Point Accumulator Float Peeler

This block turns one wide two's-complement fixed-point word, whose binary point sits a fixed number of bits above the least significant bit, into a binary floating-point value plus an exact remainder. It finds the most significant set bit of the magnitude. The float takes that bit as its hidden one and the bits directly below it as its fraction. The bits copied into the float are then cleared from the magnitude, and the result, carrying the input's sign, is returned as the remainder. No carry ripples through this step. Input equals float plus remainder, exactly.

Feeding the remainder back in again and again breaks a long accumulator into a sum of floats that do not overlap. A second mode builds no float and reports only the accumulator bit index where the extraction would stop. The leading-one search walks the word from the top, one chunk per clock. The latency therefore depends on where the highest set bit lies. A `done` pulse marks the cycle in which all results are valid.

Top module: `fxp_peel`

## Requirements
- R1: For a nonzero input in float mode, with the leading one of the magnitude at bit L, the float is {sign, exponent, fraction}. The sign is at the top and the fraction is in the low MANT_W bits. When L - FRAC_W + BIAS >= 1, where BIAS = 2^(EXP_W-1) - 1, the exponent field equals L - FRAC_W + BIAS. The fraction is magnitude bits L-1 down to L-MANT_W, and bits below bit 0 read as zero.
- R2: When L - FRAC_W + BIAS < 1, the exponent field is 0 and the fraction is subnormal. Magnitude bits FRAC_W-BIAS down to FRAC_W-BIAS+1-MANT_W fill the fraction from its top bit down.
- R3: The remainder output, read as a signed ACC_W-bit word, equals the input minus the value of the float. Its magnitude is the input magnitude with the copied bit field cleared. When it is nonzero, it has the sign of the input.
- R4: A negative input is handled through its magnitude, and the float sign bit is set.
- R5: A zero input gives an all-zero float, a zero remainder, last index 0 and `zero_o` = 1. A nonzero input gives `zero_o` = 0.
- R6: `last_idx_o` is the signed accumulator bit index of the lowest fraction bit: L - MANT_W for a normal result and FRAC_W - BIAS + 1 - MANT_W for a subnormal one.
- R7: With `idx_mode_i` = 1 at start, the float output is 0 and the remainder equals the input. `last_idx_o` and `zero_o` are reported as in R5 and R6.
- R8: `done_o` is high for exactly one cycle. With the start sampled at clock edge 0, `done_o` is high after edge s, where s = ACC_W/CHUNK_W - floor(L/CHUNK_W), or s = ACC_W/CHUNK_W for a zero input.
- R9: A start while `busy_o` is high is ignored, and the pending result is unaffected.
- R10: After reset, `done_o`, `busy_o` and all result outputs are 0. The result outputs change only in a cycle where `done_o` is high, and they hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an extraction when idle |
| idx_mode_i | input | 1 | 1 = report only the last bit index |
| acc_i | input | ACC_W | Two's-complement fixed-point input, FRAC_W fraction bits |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| zero_o | output | 1 | Input was zero |
| flt_o | output | 1+EXP_W+MANT_W | Extracted float {sign, exponent, fraction} |
| resid_o | output | ACC_W | Signed remainder, same binary point as the input |
| last_idx_o | output | IDX_W | Signed bit index of the lowest extracted bit |

## Verification
The hardest case to reach is the subnormal path. With the default parameters it needs the leading one in the two lowest accumulator bits. Only a tiny input such as 1 or 2 gets there, and such an input also takes the slowest, full-length scan. The bench drives those values on purpose, together with values whose leading one falls on every chunk boundary. It then peels random accumulators repeatedly until the remainder reaches zero, so the remainders of earlier rounds drive the deeper positions and the subnormal tail. The most negative input and a start raised during a long scan are also steered explicitly.

// File: rtl/fxp_peel_pkg.sv
// Shared types for the fixed-point float peeler.
package fxp_peel_pkg;
    // State of the chunked leading-one search
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_st_e;
endpackage

// File: rtl/fxp_peel_lead.sv
// Priority encoder for one chunk: reports whether any bit is set and the
// index of the highest set bit. Assumes PW bits can hold W-1.
module fxp_peel_lead #(
    parameter int W  = 8,
    parameter int PW = 3
) (
    input  logic [W-1:0]  vec_i,
    output logic          hit_o,
    output logic [PW-1:0] pos_o
);
    // Highest set bit wins because later iterations overwrite earlier ones
    always_comb begin
        hit_o = |vec_i;
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) pos_o = PW'(i);
        end
    end
endmodule

// File: rtl/fxp_peel_scan.sv
// Iterative leading-one search over CHUNK_W-bit chunks, starting from the
// top chunk and stepping down one chunk per clock. fin_o is raised
// combinationally in the cycle the search resolves. Assumes ACC_W is a
// multiple of CHUNK_W and mag_i is stable while busy.
module fxp_peel_scan
    import fxp_peel_pkg::*;
#(
    parameter int ACC_W   = 64,
    parameter int CHUNK_W = 8,
    localparam int LW     = $clog2(ACC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [ACC_W-1:0] mag_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic             empty_o,
    output logic [LW-1:0]    lead_o
);
    localparam int NCH = ACC_W / CHUNK_W;
    localparam int PW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CPW = (CHUNK_W > 1) ? $clog2(CHUNK_W) : 1;

    logic [NCH-1:0] hit;
    logic [CPW-1:0] pos [NCH];
    scan_st_e       st_q;
    logic [PW-1:0]  ptr_q;

    // One encoder per chunk
    for (genvar g = 0; g < NCH; g++) begin : g_chunk
        fxp_peel_lead #(.W(CHUNK_W), .PW(CPW)) u_lead (
            .vec_i (mag_i[g*CHUNK_W +: CHUNK_W]),
            .hit_o (hit[g]),
            .pos_o (pos[g])
        );
    end

    assign busy_o  = (st_q == SC_SCAN);
    assign fin_o   = busy_o && (hit[ptr_q] || (ptr_q == '0));
    assign empty_o = !hit[ptr_q];
    assign lead_o  = LW'(ptr_q) * LW'(CHUNK_W) + LW'(pos[ptr_q]);

    // Search sequencer: load at top chunk, step down until a hit or chunk 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SC_IDLE;
            ptr_q <= '0;
        end else begin
            case (st_q)
                SC_IDLE: if (load_i) begin
                    st_q  <= SC_SCAN;
                    ptr_q <= PW'(NCH - 1);
                end
                SC_SCAN: if (fin_o) st_q <= SC_IDLE;
                         else       ptr_q <= ptr_q - 1'b1;
                default: st_q <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fxp_peel_pack.sv
// Builds the float, the remainder and the last bit index from the
// magnitude and the leading-one position. Purely combinational. Assumes
// the parameters keep the largest exponent below the all-ones code.
module fxp_peel_pack #(
    parameter int ACC_W  = 64,
    parameter int FRAC_W = 32,
    parameter int EXP_W  = 6,
    parameter int MANT_W = 23,
    localparam int LW    = $clog2(ACC_W),
    localparam int FLT_W = 1 + EXP_W + MANT_W,
    localparam int IDX_W = $clog2(ACC_W + MANT_W + (1 << EXP_W)) + 1
) (
    input  logic [ACC_W-1:0] mag_i,
    input  logic             neg_i,
    input  logic             mode_i,
    input  logic             empty_i,
    input  logic [LW-1:0]    lead_i,
    output logic [FLT_W-1:0] flt_o,
    output logic [ACC_W-1:0] resid_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    int                top;
    int                lo;
    int                ex;
    logic [MANT_W-1:0] frac;
    logic [ACC_W-1:0]  kept;

    // Choose hidden-bit position and exponent, normal or subnormal
    always_comb begin
        ex = int'(lead_i) - FRAC_W + BIAS;
        if (ex >= 1) begin
            top = int'(lead_i);
        end else begin
            ex  = 0;
            top = FRAC_W - BIAS + 1;
        end
        lo = top - MANT_W;
    end

    // Gather the fraction bits and clear the copied field from the magnitude
    always_comb begin
        frac = '0;
        for (int j = 0; j < MANT_W; j++) begin
            if ((lo + j >= 0) && (lo + j < ACC_W)) frac[j] = mag_i[lo + j];
        end
        kept = mag_i;
        for (int i = 0; i < ACC_W; i++) begin
            if ((i >= lo) && (i <= top)) kept[i] = 1'b0;
        end
    end

    // Final selection by mode and zero input
    always_comb begin
        if (empty_i) begin
            flt_o   = '0;
            resid_o = '0;
            idx_o   = '0;
        end else if (mode_i) begin
            flt_o   = '0;
            resid_o = neg_i ? -mag_i : mag_i;
            idx_o   = IDX_W'(lo);
        end else begin
            flt_o   = {neg_i, EXP_W'(ex), frac};
            resid_o = neg_i ? -kept : kept;
            idx_o   = IDX_W'(lo);
        end
    end
endmodule

// File: rtl/fxp_peel.sv
// Top of the fixed-point float peeler. Captures the input magnitude on
// start, runs the chunked search, then registers float, remainder and
// index for one done pulse. Starts while busy are ignored.
module fxp_peel #(
    parameter int ACC_W   = 64,
    parameter int FRAC_W  = 32,
    parameter int EXP_W   = 6,
    parameter int MANT_W  = 23,
    parameter int CHUNK_W = 8,
    localparam int LW     = $clog2(ACC_W),
    localparam int FLT_W  = 1 + EXP_W + MANT_W,
    localparam int IDX_W  = $clog2(ACC_W + MANT_W + (1 << EXP_W)) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             idx_mode_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             zero_o,
    output logic [FLT_W-1:0] flt_o,
    output logic [ACC_W-1:0] resid_o,
    output logic [IDX_W-1:0] last_idx_o
);
    logic [ACC_W-1:0] mag_q;
    logic             neg_q;
    logic             mode_q;
    logic             load;
    logic             fin;
    logic             empty;
    logic [LW-1:0]    lead;
    logic [FLT_W-1:0] flt_n;
    logic [ACC_W-1:0] resid_n;
    logic [IDX_W-1:0] idx_n;

    assign load = start_i && !busy_o;

    // Capture magnitude, sign and mode of an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q  <= '0;
            neg_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (load) begin
            mag_q  <= acc_i[ACC_W-1] ? -acc_i : acc_i;
            neg_q  <= acc_i[ACC_W-1];
            mode_q <= idx_mode_i;
        end
    end

    fxp_peel_scan #(.ACC_W(ACC_W), .CHUNK_W(CHUNK_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .mag_i   (mag_q),
        .busy_o  (busy_o),
        .fin_o   (fin),
        .empty_o (empty),
        .lead_o  (lead)
    );

    fxp_peel_pack #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W),
                    .MANT_W(MANT_W)) u_pack (
        .mag_i   (mag_q),
        .neg_i   (neg_q),
        .mode_i  (mode_q),
        .empty_i (empty),
        .lead_i  (lead),
        .flt_o   (flt_n),
        .resid_o (resid_n),
        .idx_o   (idx_n)
    );

    // Register results when the search resolves; pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            zero_o     <= 1'b0;
            flt_o      <= '0;
            resid_o    <= '0;
            last_idx_o <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                zero_o     <= empty;
                flt_o      <= flt_n;
                resid_o    <= resid_n;
                last_idx_o <= idx_n;
            end
        end
    end
endmodule

// File: rtl/fxp_peel_chk.sv
// Protocol and result checks for fxp_peel, bound into every instance.
module fxp_peel_chk #(
    parameter int ACC_W  = 64,
    parameter int FRAC_W = 32,
    parameter int EXP_W  = 6,
    parameter int MANT_W = 23,
    parameter int FLT_W  = 30,
    parameter int IDX_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             zero_o,
    input logic [FLT_W-1:0] flt_o,
    input logic [ACC_W-1:0] resid_o,
    input logic [IDX_W-1:0] last_idx_o,
    input logic [ACC_W-1:0] mag_q,
    input logic             neg_q,
    input logic             mode_q
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> ($stable(mag_q) && $stable(neg_q) && $stable(mode_q)));

    // R5
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_o) |-> (flt_o == '0 && resid_o == '0 && last_idx_o == '0));

    // R7
    idx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q) |-> (flt_o == '0 && resid_o == (neg_q ? -mag_q : mag_q)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(flt_o) && $stable(resid_o) && $stable(last_idx_o)) |-> done_o);

    // R4
    sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_q && !zero_o) |-> (flt_o[FLT_W-1] == neg_q));

    // R3
    resid_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && resid_o != '0) |-> (resid_o[ACC_W-1] == neg_q));

    // R2
    subnormal_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_q && !zero_o && flt_o[FLT_W-2 -: EXP_W] == '0)
        |-> (last_idx_o == IDX_W'(FRAC_W - BIAS + 1 - MANT_W)));
endmodule

bind fxp_peel fxp_peel_chk #(
    .ACC_W(ACC_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MANT_W(MANT_W),
    .FLT_W(FLT_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .zero_o     (zero_o),
    .flt_o      (flt_o),
    .resid_o    (resid_o),
    .last_idx_o (last_idx_o),
    .mag_q      (mag_q),
    .neg_q      (neg_q),
    .mode_q     (mode_q)
);

// File: tb/fxp_peel_tb.sv
// Self-checking bench: a behavioural model gives latency and results for
// each request, and done is compared on every clock of every request.
module fxp_peel_tb;
    localparam int ACC_W   = 64;
    localparam int FRAC_W  = 32;
    localparam int EXP_W   = 6;
    localparam int MANT_W  = 23;
    localparam int CHUNK_W = 8;
    localparam int FLT_W   = 1 + EXP_W + MANT_W;
    localparam int IDX_W   = $clog2(ACC_W + MANT_W + (1 << EXP_W)) + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int NCH     = ACC_W / CHUNK_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             idx_mode_i = 1'b0;
    logic [ACC_W-1:0] acc_i = '0;
    logic             busy_o, done_o, zero_o;
    logic [FLT_W-1:0] flt_o;
    logic [ACC_W-1:0] resid_o;
    logic [IDX_W-1:0] last_idx_o;

    int  errors = 0;
    int  checks = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    fxp_peel #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W),
               .MANT_W(MANT_W), .CHUNK_W(CHUNK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .idx_mode_i(idx_mode_i),
        .acc_i(acc_i), .busy_o(busy_o), .done_o(done_o), .zero_o(zero_o),
        .flt_o(flt_o), .resid_o(resid_o), .last_idx_o(last_idx_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: results and latency from the requirements
    task automatic model(input logic [ACC_W-1:0] a, input bit m,
                         output logic [FLT_W-1:0] f, output logic [ACC_W-1:0] r,
                         output logic [IDX_W-1:0] ix, output bit z, output int lat);
        logic [ACC_W-1:0] mag;
        logic [191:0]     big;
        logic [191:0]     low;
        logic [ACC_W-1:0] rm;
        int               lead, e, top, lo;
        bit               neg;
        neg  = a[ACC_W-1];
        mag  = neg ? -a : a;
        lead = -1;
        for (int i = 0; i < ACC_W; i++) if (mag[i]) lead = i;
        if (lead < 0) begin
            f = '0; r = '0; ix = '0; z = 1'b1; lat = NCH;
            return;
        end
        z   = 1'b0;
        lat = NCH - lead / CHUNK_W;
        e   = lead - FRAC_W + BIAS;
        if (e >= 1) top = lead;
        else begin e = 0; top = FRAC_W - BIAS + 1; end
        lo  = top - MANT_W;
        ix  = IDX_W'(lo);
        big = {64'b0, mag, 64'b0};
        low = big & ((192'd1 << (lo + 64)) - 192'd1);
        rm  = low[64 +: ACC_W];
        if (m) begin
            f = '0; r = a;
        end else begin
            f = {neg, EXP_W'(e), MANT_W'(big >> (lo + 64))};
            r = neg ? -rm : rm;
        end
    endtask

    // Fixed-point value of a float at the accumulator's binary point
    function automatic logic [ACC_W-1:0] recon(input logic [FLT_W-1:0] f);
        logic [EXP_W-1:0] e;
        logic [191:0]     sig;
        logic [ACC_W-1:0] v;
        int               lsb;
        e   = f[FLT_W-2 -: EXP_W];
        sig = (e != 0) ? (192'(f[MANT_W-1:0]) | (192'd1 << MANT_W)) : 192'(f[MANT_W-1:0]);
        lsb = ((e != 0) ? int'(e) : 1) - BIAS + FRAC_W - MANT_W;
        sig = sig << (lsb + 64);
        v   = sig[64 +: ACC_W];
        return f[FLT_W-1] ? -v : v;
    endfunction

    // One request; poke = raise a second start while busy (R9)
    task automatic run(input logic [ACC_W-1:0] a, input bit m, input bit poke);
        logic [FLT_W-1:0] ef;
        logic [ACC_W-1:0] er;
        logic [IDX_W-1:0] ei;
        bit               ez;
        int               lat;
        model(a, m, ef, er, ei, ez, lat);
        @(negedge clk);
        start_i = 1'b1; acc_i = a; idx_mode_i = m;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c <= lat; c++) begin
            if (poke && c == 1) begin
                start_i = 1'b1; acc_i = ~a; idx_mode_i = !m;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(done_o == (c == lat), "R8", "done timing", 128'(done_o), 128'(c == lat));
        end
        check(flt_o == ef, m ? "R7" : "R1", "float", 128'(flt_o), 128'(ef));
        check(resid_o == er, m ? "R7" : "R3", "residual", 128'(resid_o), 128'(er));
        check(last_idx_o == ei, "R6", "last index", 128'(last_idx_o), 128'(ei));
        check(zero_o == ez, "R5", "zero flag", 128'(zero_o), 128'(ez));
        if (!m)
            check(recon(flt_o) + resid_o == a, "R3", "float+residual", 128'(recon(flt_o) + resid_o), 128'(a));
        @(negedge clk);
        check(!done_o, "R8", "done one cycle", 128'(done_o), 128'(0));
        check(flt_o == ef && resid_o == er, "R10", "outputs hold", 128'(flt_o), 128'(ef));
    endtask

    // Peel until the remainder is zero; the floats must sum to the input
    task automatic peel(input logic [ACC_W-1:0] a);
        logic [ACC_W-1:0] x, sum;
        x = a; sum = '0;
        for (int k = 0; k < 8 && x != '0; k++) begin
            run(x, 1'b0, 1'b0);
            sum = sum + recon(flt_o);
            x   = resid_o;
        end
        check(x == '0 && sum == a, "R3", "peeled sum", 128'(sum), 128'(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!done_o && !busy_o && flt_o == '0 && resid_o == '0 && last_idx_o == '0,
              "R10", "reset state", 128'(flt_o), 128'(0));
        rst_n = 1'b1;
        // R1: 1.0 -> exponent 31, fraction 0, index 9
        run(64'h0000_0001_0000_0000, 1'b0, 1'b0);
        check(flt_o == 30'h0F80_0000, "R1", "one", 128'(flt_o), 128'h0F80_0000);
        // R4: -1.0
        run(-64'sh0000_0001_0000_0000, 1'b0, 1'b0);
        check(flt_o == 30'h2F80_0000, "R4", "minus one", 128'(flt_o), 128'h2F80_0000);
        // R3: bit below the field stays in the residual
        run(64'h0000_0001_0000_0001, 1'b0, 1'b0);
        check(resid_o == 64'd1, "R3", "tail bit", 128'(resid_o), 128'd1);
        // R2: smallest value is subnormal, fraction bit 21, index -21
        run(64'd1, 1'b0, 1'b0);
        check(flt_o == 30'h0020_0000, "R2", "subnormal", 128'(flt_o), 128'h0020_0000);
        run(64'd3, 1'b0, 1'b0);
        // R5: zero input
        run(64'd0, 1'b0, 1'b0);
        // most negative input
        run(64'h8000_0000_0000_0000, 1'b0, 1'b0);
        // R8: leading one at each chunk boundary
        for (int b = 0; b < ACC_W; b += CHUNK_W) run(64'd1 << b, 1'b0, 1'b0);
        for (int b = CHUNK_W - 1; b < ACC_W; b += CHUNK_W) run(64'd1 << b, 1'b0, 1'b0);
        // R7: index-only mode
        run(64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
        run(-64'sd12345, 1'b1, 1'b0);
        run(64'd0, 1'b1, 1'b0);
        // R9: start while busy is ignored
        run(64'd1, 1'b0, 1'b1);
        run(64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1'b1);
        // random values, both modes, then full peeling
        for (int k = 0; k < 40; k++)
            run({$urandom, $urandom} >> ($urandom % 64), k[0], 1'b0);
        for (int k = 0; k < 20; k++) peel({$urandom, $urandom} >> ($urandom % 40));
        peel(64'hFFFF_FFFF_FFFF_FFFF);
        peel(64'h7FFF_FFFF_FFFF_FFFF);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule